// File: doc/BRIEF.md
# TLB Test-Register Access Unit

This block is a small set-associative translation lookaside buffer that is reached only through two 32-bit test registers. A command register carries a linear address, a valid bit, three protection attributes encoded as complementary bit pairs, and an operation bit. A data register carries a physical address, two cache-control bits, the replacement-tree state, a hit/select flag and a two-bit way field. Writing the command register both stores it and runs the operation in the same clock cycle: either an entry is installed, or the addressed set is searched and the result is merged into the data register.

The array holds 8 sets of 4 ways. The set index is taken from the low bits of the linear address, and the remaining upper address bits form the stored tag. Each attribute pair lets software force an unconditional miss, demand an exact 0 or 1, or ignore the attribute during a search. On an install, the same pair selects whether a 0 or a 1 is stored. A tree pseudo-LRU per set chooses the victim way when software does not name one.

Both register ports are plain write strobes with no back-pressure. The block accepts a strobe on every cycle and finishes every operation in a single cycle, so no valid/ready handshake is needed.

Top module: `tlb_test_unit`

## Requirements
- R1: Command bit 0 selects the operation: 0 installs an entry and 1 searches. The operation runs in the cycle in which the command strobe is high, and its effect is visible after the next rising edge. An install leaves the data register unchanged.
- R2: The command register reads back the last value written to it, one cycle after the strobe.
- R3: Linear-address bits 14:12 (command bits 14:12) select the set, and bits 31:15 form the tag. A way can hit only if its stored valid bit is 1 and its stored tag equals the tag of the command. Command bit 11 is the valid bit that an install stores.
- R4: On an install, each attribute pair (command bits 10:9 for dirty, 8:7 for user, 6:5 for writable; the upper bit of each pair is B and the lower bit is B#) acts as follows: 01 stores 0, 10 stores 1, and 00 or 11 leaves the bit already stored in the target way unchanged.
- R5: On a search, each attribute pair acts as follows: 00 never matches, 01 matches a stored 0, 10 matches a stored 1, and 11 matches either value. A way hits only if all three pairs match.
- R6: On a search hit, the data register receives the following: the stored physical address in bits 31:12, PCD in bit 11, PWT in bit 10, the set's replacement state before the search in bits 9:7, a 1 in bit 4, and the hitting way in bits 3:2. Bits 6:5 and 1:0 are kept.
- R7: When several ways hit, the lowest-numbered way is reported.
- R8: On a search miss, data bit 4 is cleared and every other data bit is left unchanged.
- R9: On an install with data bit 4 set, the target is the way in data bits 3:2. With data bit 4 clear, the target is the way chosen by the replacement tree, and bits 3:2 are ignored.
- R10: The replacement state is 3 bits per set, {b2,b1,b0}. The victim is way (b1 ? 1 : 0) when b0 is 0, and way (b2 ? 3 : 2) when b0 is 1. An install, or a search hit, on way 0/1/2/3 sets {b0=1,b1=1}, {b0=1,b1=0}, {b0=0,b2=1} or {b0=0,b2=0} respectively, and leaves the other bit unchanged.
- R11: Reset clears both registers, marks every entry invalid and clears all replacement state.
- R12: A data strobe loads the data register. When the data and command strobes are high in the same cycle, the operation uses the new data value. With neither strobe high, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe; starts the operation |
| cmd_wdata | input | 32 | Command register write value |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 32 | Data register write value |
| cmd_q | output | 32 | Command register contents |
| dat_q | output | 32 | Data register contents |

## Verification
Every result of this block is due exactly one rising edge after the strobe that caused it. This covers the command readback, the merged search result, the cleared hit flag and the array contents that a later search sees. The bench drives each strobe on a falling edge, drops it on the next falling edge, and samples both registers at that same falling edge, half a cycle after the updating edge. An install is always observed through a later search, which reports the way, the stored attributes and the replacement state in the data register.

// File: rtl/tlbt_pkg.sv
`timescale 1ns/1ps
package tlbt_pkg;
  localparam int LA_W = 20;

  // command register fields
  localparam int CB_OP  = 0;
  localparam int CB_VLD = 11;
  localparam int CB_DP  = 9;  // dirty pair at 10:9
  localparam int CB_UP  = 7;  // user pair at 8:7
  localparam int CB_WP  = 5;  // writable pair at 6:5

  // data register fields
  localparam int DB_PCD = 11;
  localparam int DB_PWT = 10;
  localparam int DB_LRU = 7;  // 9:7
  localparam int DB_HIT = 4;
  localparam int DB_WAY = 2;  // 3:2

  typedef enum logic {OP_WRITE = 1'b0, OP_LOOKUP = 1'b1} tlbt_op_e;

  function automatic logic pair_write(input logic [1:0] pr, input logic old);
    case (pr)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return old;
    endcase
  endfunction

  function automatic logic pair_match(input logic [1:0] pr, input logic st);
    case (pr)
      2'b00:   return 1'b0;
      2'b01:   return ~st;
      2'b10:   return st;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/tlbt_way_match.sv
`timescale 1ns/1ps
module tlbt_way_match #(
  parameter int TAG_W = 17
) (
  input  logic             valid,
  input  logic [TAG_W-1:0] tag_st,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [2:0]       attr_st,  // {dirty, user, writable}
  input  logic [5:0]       pairs,    // {dirty pair, user pair, writable pair}
  output logic             hit
);
  import tlbt_pkg::*;
  logic [2:0] attr_ok;

  always_comb begin
    attr_ok[2] = pair_match(pairs[5:4], attr_st[2]);
    attr_ok[1] = pair_match(pairs[3:2], attr_st[1]);
    attr_ok[0] = pair_match(pairs[1:0], attr_st[0]);
    hit = valid && (tag_st == tag_in) && (&attr_ok);
  end
endmodule

// File: rtl/tlbt_prio.sv
`timescale 1ns/1ps
module tlbt_prio #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  req,
  output logic             any,
  output logic [WAY_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlbt_plru.sv
`timescale 1ns/1ps
module tlbt_plru (
  input  logic [2:0] state,      // {b2, b1, b0}
  input  logic [1:0] touch_way,
  output logic [1:0] victim,
  output logic [2:0] next_state
);
  always_comb begin
    if (!state[0]) victim = state[1] ? 2'd1 : 2'd0;
    else           victim = state[2] ? 2'd3 : 2'd2;

    next_state = state;
    if (!touch_way[1]) begin
      next_state[0] = 1'b1;
      next_state[1] = ~touch_way[0];
    end else begin
      next_state[0] = 1'b0;
      next_state[2] = ~touch_way[0];
    end
  end
endmodule

// File: rtl/tlb_test_unit.sv
`timescale 1ns/1ps
module tlb_test_unit #(
  parameter int SETS = 8,
  parameter int WAYS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        dat_we,
  input  logic [31:0] dat_wdata,
  output logic [31:0] cmd_q,
  output logic [31:0] dat_q
);
  import tlbt_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LA_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  // command decode
  logic [LA_W-1:0]  la;
  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_in;
  logic [5:0]       pairs;
  logic             do_wr, do_lk;
  logic [31:0]      dat_eff;

  assign la      = cmd_wdata[31:12];
  assign set_idx = la[IDX_W-1:0];
  assign tag_in  = la[LA_W-1:IDX_W];
  assign pairs   = {cmd_wdata[CB_DP +: 2], cmd_wdata[CB_UP +: 2], cmd_wdata[CB_WP +: 2]};
  assign do_wr   = cmd_we && (tlbt_op_e'(cmd_wdata[CB_OP]) == OP_WRITE);
  assign do_lk   = cmd_we && (tlbt_op_e'(cmd_wdata[CB_OP]) == OP_LOOKUP);
  assign dat_eff = dat_we ? dat_wdata : dat_q;

  // entry storage
  logic [WAYS-1:0]  valid_q [SETS];
  logic [2:0]       lru_q   [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [LA_W-1:0]  pa_q    [SETS][WAYS];
  logic [2:0]       attr_q  [SETS][WAYS];  // {dirty, user, writable}
  logic [1:0]       cc_q    [SETS][WAYS];  // {pcd, pwt}

  // per-way match
  logic [WAYS-1:0] hit_vec;
  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_way
      tlbt_way_match #(.TAG_W(TAG_W)) u_match (
        .valid   (valid_q[set_idx][gw]),
        .tag_st  (tag_q[set_idx][gw]),
        .tag_in  (tag_in),
        .attr_st (attr_q[set_idx][gw]),
        .pairs   (pairs),
        .hit     (hit_vec[gw])
      );
    end
  endgenerate

  logic             hit_any;
  logic [WAY_W-1:0] hit_way;
  tlbt_prio #(.WAYS(WAYS)) u_prio (.req(hit_vec), .any(hit_any), .idx(hit_way));

  // replacement
  logic [WAY_W-1:0] victim, tgt_way, touch_way;
  logic [2:0]       lru_nxt;

  assign tgt_way   = dat_eff[DB_HIT] ? dat_eff[DB_WAY +: WAY_W] : victim;
  assign touch_way = do_lk ? hit_way : tgt_way;

  tlbt_plru u_plru (
    .state      (lru_q[set_idx]),
    .touch_way  (touch_way),
    .victim     (victim),
    .next_state (lru_nxt)
  );

  // state with reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        lru_q[s]   <= '0;
      end
    end else begin
      if (do_wr) valid_q[set_idx][tgt_way] <= cmd_wdata[CB_VLD];
      if (do_wr || (do_lk && hit_any)) lru_q[set_idx] <= lru_nxt;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (do_wr) begin
      tag_q[set_idx][tgt_way]     <= tag_in;
      pa_q[set_idx][tgt_way]      <= dat_eff[31:12];
      cc_q[set_idx][tgt_way]      <= {dat_eff[DB_PCD], dat_eff[DB_PWT]};
      attr_q[set_idx][tgt_way][2] <= pair_write(pairs[5:4], attr_q[set_idx][tgt_way][2]);
      attr_q[set_idx][tgt_way][1] <= pair_write(pairs[3:2], attr_q[set_idx][tgt_way][1]);
      attr_q[set_idx][tgt_way][0] <= pair_write(pairs[1:0], attr_q[set_idx][tgt_way][0]);
    end
  end

  // lookup result merge
  logic [31:0] dat_lk;
  always_comb begin
    dat_lk = dat_eff;
    dat_lk[DB_HIT] = hit_any;
    if (hit_any) begin
      dat_lk[31:12]               = pa_q[set_idx][hit_way];
      dat_lk[DB_PCD]              = cc_q[set_idx][hit_way][1];
      dat_lk[DB_PWT]              = cc_q[set_idx][hit_way][0];
      dat_lk[DB_LRU +: 3]         = lru_q[set_idx];
      dat_lk[DB_WAY +: WAY_W]     = hit_way;
    end
  end

  // test registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      dat_q <= '0;
    end else begin
      if (cmd_we) cmd_q <= cmd_wdata;
      if (do_lk)       dat_q <= dat_lk;
      else if (dat_we) dat_q <= dat_wdata;
    end
  end
endmodule

// File: rtl/tlbt_checker.sv
`timescale 1ns/1ps
module tlbt_checker #(
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_we,
  input logic [31:0]     cmd_wdata,
  input logic            dat_we,
  input logic [31:0]     cmd_q,
  input logic [31:0]     dat_q,
  input logic [WAYS-1:0] hit_vec
);
  a_r2_cmd_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> cmd_q == $past(cmd_wdata));

  a_r6_hit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[0]) |=> dat_q[4] == $past(|hit_vec));

  a_r7_lowest_way: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[0] && hit_vec[0]) |=> dat_q[3:2] == 2'd0);

  a_r8_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[0] && hit_vec == '0 && !dat_we)
      |=> dat_q == ($past(dat_q) & ~32'h0000_0010));

  a_r1_write_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !cmd_wdata[0] && !dat_we) |=> $stable(dat_q));

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we && !dat_we) |=> ($stable(dat_q) && $stable(cmd_q)));
endmodule

bind tlb_test_unit tlbt_checker #(.WAYS(WAYS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_we    (cmd_we),
  .cmd_wdata (cmd_wdata),
  .dat_we    (dat_we),
  .cmd_q     (cmd_q),
  .dat_q     (dat_q),
  .hit_vec   (hit_vec)
);

// File: tb/tlb_test_unit_test.sv
`timescale 1ns/1ps
module tlb_test_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        dat_we = 1'b0;
  logic [31:0] dat_wdata = '0;
  logic [31:0] cmd_q, dat_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlb_test_unit uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .cmd_q(cmd_q), .dat_q(dat_q)
  );

  function automatic logic [31:0] mk_cmd(input logic [19:0] la, input logic v,
      input logic [1:0] d, input logic [1:0] u, input logic [1:0] w, input logic op);
    return {la, v, d, u, w, 4'b0000, op};
  endfunction

  function automatic logic [31:0] mk_dat(input logic [19:0] pa, input logic pcd,
      input logic pwt, input logic [2:0] lru, input logic sel, input logic [1:0] way);
    return {pa, pcd, pwt, lru, 2'b00, sel, way, 2'b00};
  endfunction

  // {data written, command written, expected data register}
  localparam int NV = 20;
  localparam logic [95:0] VEC [NV] = '{
    {mk_dat(20'hABCDE,1,0,3'b000,1,2), mk_cmd(20'h12341,1,2'b10,2'b01,2'b10,0), mk_dat(20'hABCDE,1,0,3'b000,1,2)},
    {32'h0,                            mk_cmd(20'h12341,0,2'b11,2'b11,2'b11,1), mk_dat(20'hABCDE,1,0,3'b100,1,2)},
    {32'h5555_5555,                    mk_cmd(20'h12341,0,2'b01,2'b11,2'b11,1), 32'h5555_5545},
    {32'h0,                            mk_cmd(20'h12341,0,2'b10,2'b01,2'b10,1), mk_dat(20'hABCDE,1,0,3'b100,1,2)},
    {32'hFFFF_FFFF,                    mk_cmd(20'h12341,0,2'b00,2'b11,2'b11,1), 32'hFFFF_FFEF},
    {32'h0000_0010,                    mk_cmd(20'h12341,0,2'b11,2'b10,2'b11,1), 32'h0},
    {mk_dat(20'h11111,0,1,3'b000,0,3), mk_cmd(20'h00009,1,2'b01,2'b10,2'b01,0), mk_dat(20'h11111,0,1,3'b000,0,3)},
    {32'h0,                            mk_cmd(20'h00009,0,2'b11,2'b11,2'b11,1), mk_dat(20'h11111,0,1,3'b111,1,0)},
    {mk_dat(20'h22222,1,1,3'b000,1,0), mk_cmd(20'h00009,1,2'b00,2'b11,2'b00,0), mk_dat(20'h22222,1,1,3'b000,1,0)},
    {32'h0,                            mk_cmd(20'h00009,0,2'b01,2'b10,2'b01,1), mk_dat(20'h22222,1,1,3'b111,1,0)},
    {mk_dat(20'h00000,0,0,3'b000,1,2), mk_cmd(20'h12341,0,2'b10,2'b01,2'b10,0), mk_dat(20'h00000,0,0,3'b000,1,2)},
    {32'h0,                            mk_cmd(20'h12341,0,2'b11,2'b11,2'b11,1), 32'h0},
    {mk_dat(20'h33333,0,0,3'b000,1,3), mk_cmd(20'h12341,1,2'b10,2'b10,2'b10,0), mk_dat(20'h33333,0,0,3'b000,1,3)},
    {mk_dat(20'h44444,0,0,3'b000,1,1), mk_cmd(20'h12341,1,2'b01,2'b01,2'b01,0), mk_dat(20'h44444,0,0,3'b000,1,1)},
    {32'h0,                            mk_cmd(20'h12341,0,2'b11,2'b11,2'b11,1), mk_dat(20'h44444,0,0,3'b001,1,1)},
    {32'h0,                            mk_cmd(20'h12341,0,2'b10,2'b11,2'b11,1), mk_dat(20'h33333,0,0,3'b001,1,3)},
    {32'h0000_0014,                    mk_cmd(20'h12342,0,2'b11,2'b11,2'b11,1), 32'h0000_0004},
    {mk_dat(20'h55555,1,1,3'b000,0,2), mk_cmd(20'h00001,1,2'b10,2'b10,2'b10,0), mk_dat(20'h55555,1,1,3'b000,0,2)},
    {32'h0,                            mk_cmd(20'h00001,0,2'b11,2'b11,2'b11,1), mk_dat(20'h55555,1,1,3'b011,1,0)},
    {32'h0,                            mk_cmd(20'h00009,0,2'b11,2'b11,2'b11,1), 32'h0}
  };

  string vtag [NV] = '{
    "R1 R9 write way2 by pointer", "R6 hit way2 dont-care pairs", "R5 R8 exact-0 on dirty=1 misses",
    "R5 exact pairs hit", "R5 forced miss pair 00", "R5 exact-1 on user=0 misses",
    "R9 R10 write by tree victim", "R10 lookup reports tree state", "R4 undefined pairs keep bits",
    "R4 kept attributes still match", "R3 write with valid clear", "R3 invalid entry misses",
    "R9 write way3", "R9 write way1", "R7 two hits report way1",
    "R7 attribute picks way3", "R3 other set misses", "R10 victim after tree state 000",
    "R10 hit way0 state 011", "R10 evicted tag misses"
  };

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] d, input logic [31:0] c);
    @(negedge clk);
    dat_we = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_we = 1'b0; cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 command register after reset", cmd_q, 32'h0);
    check("R11 data register after reset", dat_q, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][95:64], VEC[i][63:32]);
      check(vtag[i], dat_q, VEC[i][31:0]);
      check("R2 command readback", cmd_q, VEC[i][63:32]);
    end

    // R12: both strobes together, the search uses the new data value
    @(negedge clk);
    dat_we = 1'b1; dat_wdata = 32'h0000_00E0;
    cmd_we = 1'b1; cmd_wdata = mk_cmd(20'h00001,0,2'b11,2'b11,2'b11,1);
    @(negedge clk);
    dat_we = 1'b0; cmd_we = 1'b0;
    check("R12 same-cycle strobes", dat_q, mk_dat(20'h55555,1,1,3'b011,1,0) | 32'h0000_0060);

    // R12: idle cycles hold both registers
    repeat (3) @(negedge clk);
    check("R12 idle holds data", dat_q, mk_dat(20'h55555,1,1,3'b011,1,0) | 32'h0000_0060);
    check("R12 idle holds command", cmd_q, mk_cmd(20'h00001,0,2'b11,2'b11,2'b11,1));

    // R8: miss with only the hit flag set in the data register
    run_op(32'h0000_0010, mk_cmd(20'h00005,0,2'b11,2'b11,2'b11,1));
    check("R8 miss clears only hit flag", dat_q, 32'h0);

    // R11: reset mid-run invalidates the array
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 data cleared by reset", dat_q, 32'h0);
    check("R11 command cleared by reset", cmd_q, 32'h0);
    rst_n = 1'b1;
    run_op(32'h0, mk_cmd(20'h00001,0,2'b11,2'b11,2'b11,1));
    check("R11 entries invalid after reset", dat_q, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule